// File: doc/BRIEF.md
# Dual-Mode Debug Breakpoint Comparator

This block is the data-side breakpoint unit of a 16-bit microcontroller debug engine. It keeps a small set of breakpoint values that only commands issued while the debugger runs in background mode may read or change. The unit watches the running CPU and raises a break request so that the debug engine can take over the CPU.

One mode input picks what every breakpoint value is compared against. In address mode, the full 16-bit value is compared with the data memory address of each valid access. This check runs only while the data-breakpoint enable is set. In register mode, only the low nine bits take part. Bits 3:0 name a register module and bits 8:4 name a register index within it. They are compared with the destination register of each instruction at the cycle it writes its result. Each breakpoint slot runs in parallel, and a hit on any slot produces a request.

Top module: `dbg_brk_unit`

## Requirements
- R1: After a synchronous active-low reset, every breakpoint value reads back as 0xFFFF and `brk_req` is low.
- R2: A write with `cfg_bg_cmd`=1 and `cfg_wr_en`=1 loads `cfg_wdata` into slot `cfg_sel` at the clock edge. `cfg_rdata` shows slot `cfg_sel` when `cfg_bg_cmd`=1 and shows 0 otherwise.
- R3: A write with `cfg_wr_en`=1 but `cfg_bg_cmd`=0 (a user-program attempt) leaves every breakpoint value unchanged.
- R4: With `cfg_reg_mode`=0 (address mode), a valid access on the data bus hits a slot only when all 16 address bits equal its value. The hit makes `brk_req` high in the cycle after the access.
- R5: In address mode, no break occurs when `dmem_vld`=0 or when `cfg_dmem_en`=0, whatever the address.
- R6: With `cfg_reg_mode`=1 (register mode), a slot hits when `dst_vld`=1, `dst_mod` equals bits 3:0 of the slot, and `dst_idx` equals bits 8:4 of the slot. `brk_req` is then high in the next cycle.
- R7: In register mode, bits 15:9 are stored and read back as written, but they play no part in the comparison. Data bus activity does not cause a break in this mode.
- R8: A hit on any slot alone is enough to raise `brk_req`.
- R9: No break request is raised for a cycle in which `cpu_in_dbg`=1.
- R10: In register mode, a cycle with `dst_vld`=0 never causes a break.
- R11: `brk_req` is a pulse of one cycle for each qualifying cycle. It falls in the cycle after a qualifying cycle unless the next cycle also qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bg_cmd | input | 1 | Access comes from a background-mode debug command |
| cfg_wr_en | input | 1 | Write strobe for breakpoint values |
| cfg_sel | input | 1 | Breakpoint slot selected for read and write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected slot |
| cfg_reg_mode | input | 1 | 0: address mode, 1: register mode |
| cfg_dmem_en | input | 1 | Enables data-address breakpoints |
| cpu_in_dbg | input | 1 | CPU is in debug mode (not running the user program) |
| dmem_vld | input | 1 | Data memory access strobe |
| dmem_addr | input | 16 | Data memory address |
| dst_vld | input | 1 | Instruction writes its destination register this cycle |
| dst_mod | input | 4 | Destination register module |
| dst_idx | input | 5 | Destination register index |
| brk_req | output | 1 | Break request pulse to the debug engine |

## Verification
The hardest case to reach is register mode with reserved upper bits that differ from the incoming data address. Such a slot must still hit on module and index alone, and it must not hit on the raw bus. The stimulus stores a value whose upper seven bits are set. It then drives a destination write with the matching module and index, and separately drives a data access whose address equals the full 16-bit value. Index bit 8 gets its own case: the slot differs from the destination in that bit only, and the stimulus checks that no break follows.

// File: rtl/dbg_brk_pkg.sv
// Package: shared constants and types of the debug breakpoint unit.
// Assumes register-mode fields sit at fixed bit positions that the
// comparator decodes: module specifier low, register index above it.
package dbg_brk_pkg;
    localparam int unsigned BP_DW   = 16;
    localparam int unsigned MOD_W   = 4;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned MOD_LSB = 0;
    localparam int unsigned IDX_LSB = MOD_LSB + MOD_W;

    typedef enum logic {
        BRK_ADDR = 1'b0,
        BRK_REG  = 1'b1
    } brk_mode_e;
endpackage

// File: rtl/dbg_brk_regfile.sv
// Module: breakpoint value storage.
// Holds N_BP values of DW bits that reset to all ones. Only writes flagged
// as background-mode debug commands change them; others are dropped.
// Reads are combinational and return zero outside background commands.
module dbg_brk_regfile #(
    parameter int unsigned N_BP  = 2,
    parameter int unsigned DW    = 16,
    parameter int unsigned SEL_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bg_cmd,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic [N_BP*DW-1:0] bp_flat
);
    logic [DW-1:0] bp_q [N_BP];

    for (genvar g = 0; g < N_BP; g++) begin : g_slot
        logic slot_we;
        // Decode a debugger write aimed at this slot.
        always_comb slot_we = wr_en && bg_cmd && (sel == SEL_W'(g));

        // Store the slot value; reset to all ones.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bp_q[g] <= '1;
            end else if (slot_we) begin
                bp_q[g] <= wdata;
            end
        end

        // Expose the slot on the flat bus used by the comparators.
        always_comb bp_flat[g*DW +: DW] = bp_q[g];
    end

    // Return the selected slot to a background read, zero otherwise.
    always_comb begin
        rdata = '0;
        if (bg_cmd && (int'(sel) < int'(N_BP))) begin
            rdata = bp_q[sel];
        end
    end
endmodule

// File: rtl/dbg_brk_cmp.sv
// Module: single breakpoint comparator.
// In address mode it matches the full value against a valid, enabled data
// access. In register mode it matches the module and index fields against
// a destination write; bits above the index field are ignored.
module dbg_brk_cmp
    import dbg_brk_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic             reg_mode,
    input  logic [DW-1:0]    bp_val,
    input  logic             dmem_en,
    input  logic             dmem_vld,
    input  logic [DW-1:0]    dmem_addr,
    input  logic             dst_vld,
    input  logic [MOD_W-1:0] dst_mod,
    input  logic [IDX_W-1:0] dst_idx,
    output logic             hit
);
    logic addr_hit;
    logic reg_hit;
    logic [MOD_W-1:0] bp_mod;
    logic [IDX_W-1:0] bp_idx;

    // Pull the register-mode fields out of the stored value.
    always_comb begin
        bp_mod = bp_val[MOD_LSB +: MOD_W];
        bp_idx = bp_val[IDX_LSB +: IDX_W];
    end

    // Address compare, qualified by the enable and the access strobe.
    always_comb addr_hit = dmem_en && dmem_vld && (dmem_addr == bp_val);

    // Destination compare, qualified by the register write strobe.
    always_comb reg_hit = dst_vld && (dst_mod == bp_mod) && (dst_idx == bp_idx);

    // Select the compare that the mode calls for.
    always_comb hit = (brk_mode_e'(reg_mode) == BRK_REG) ? reg_hit : addr_hit;
endmodule

// File: rtl/dbg_brk_pulse.sv
// Module: break request stage.
// ORs the per-slot hits and registers one request per qualifying cycle.
// Assumes the hit vector is combinational from the current CPU cycle;
// hits seen while the CPU sits in debug mode are dropped.
module dbg_brk_pulse #(
    parameter int unsigned N_BP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_BP-1:0] hits,
    input  logic            cpu_in_dbg,
    output logic            brk_req
);
    logic any_hit;

    // Any slot hitting outside debug mode qualifies the cycle.
    always_comb any_hit = (|hits) && !cpu_in_dbg;

    // Register the request so it lasts exactly one cycle per event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req <= 1'b0;
        end else begin
            brk_req <= any_hit;
        end
    end
endmodule

// File: rtl/dbg_brk_unit.sv
// Module: dual-mode debug breakpoint unit (top).
// Ties storage, one comparator per slot and the request stage together.
// Assumes the mode and enable inputs come from the debug engine's control
// state and stay stable while the user program runs.
module dbg_brk_unit
    import dbg_brk_pkg::*;
#(
    parameter int unsigned N_BP  = 2,
    parameter int unsigned DW    = BP_DW,
    parameter int unsigned SEL_W = (N_BP > 1) ? $clog2(N_BP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bg_cmd,
    input  logic             cfg_wr_en,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             cfg_reg_mode,
    input  logic             cfg_dmem_en,
    input  logic             cpu_in_dbg,
    input  logic             dmem_vld,
    input  logic [DW-1:0]    dmem_addr,
    input  logic             dst_vld,
    input  logic [MOD_W-1:0] dst_mod,
    input  logic [IDX_W-1:0] dst_idx,
    output logic             brk_req
);
    logic [N_BP*DW-1:0] bp_flat;
    logic [N_BP-1:0]    hits;

    dbg_brk_regfile #(
        .N_BP  (N_BP),
        .DW    (DW),
        .SEL_W (SEL_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bg_cmd  (cfg_bg_cmd),
        .wr_en   (cfg_wr_en),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .bp_flat (bp_flat)
    );

    for (genvar g = 0; g < N_BP; g++) begin : g_cmp
        dbg_brk_cmp #(
            .DW (DW)
        ) cmp_i (
            .reg_mode  (cfg_reg_mode),
            .bp_val    (bp_flat[g*DW +: DW]),
            .dmem_en   (cfg_dmem_en),
            .dmem_vld  (dmem_vld),
            .dmem_addr (dmem_addr),
            .dst_vld   (dst_vld),
            .dst_mod   (dst_mod),
            .dst_idx   (dst_idx),
            .hit       (hits[g])
        );
    end

    dbg_brk_pulse #(
        .N_BP (N_BP)
    ) pulse_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hits       (hits),
        .cpu_in_dbg (cpu_in_dbg),
        .brk_req    (brk_req)
    );
endmodule

// File: rtl/dbg_brk_unit_chk.sv
// Module: assertion checker for dbg_brk_unit, attached by bind.
module dbg_brk_unit_chk #(
    parameter int unsigned N_BP  = 2,
    parameter int unsigned DW    = 16,
    parameter int unsigned SEL_W = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_bg_cmd,
    input logic               cfg_wr_en,
    input logic [SEL_W-1:0]   cfg_sel,
    input logic [DW-1:0]      cfg_wdata,
    input logic               cfg_reg_mode,
    input logic               cfg_dmem_en,
    input logic               cpu_in_dbg,
    input logic               dmem_vld,
    input logic               dst_vld,
    input logic               brk_req,
    input logic [N_BP*DW-1:0] bp_flat
);
    // R1
    reset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (bp_flat == '1 && !brk_req));

    // R2
    bg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_bg_cmd && cfg_sel == '0) |=> (bp_flat[DW-1:0] == $past(cfg_wdata)));

    // R3
    user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !cfg_bg_cmd) |=> $stable(bp_flat));

    // R5
    addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_reg_mode && (!dmem_vld || !cfg_dmem_en)) |=> !brk_req);

    // R9
    dbg_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_in_dbg |=> !brk_req);

    // R10
    no_dst_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reg_mode && !dst_vld) |=> !brk_req);
endmodule

bind dbg_brk_unit dbg_brk_unit_chk #(
    .N_BP  (N_BP),
    .DW    (DW),
    .SEL_W (SEL_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_bg_cmd   (cfg_bg_cmd),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .cfg_reg_mode (cfg_reg_mode),
    .cfg_dmem_en  (cfg_dmem_en),
    .cpu_in_dbg   (cpu_in_dbg),
    .dmem_vld     (dmem_vld),
    .dst_vld      (dst_vld),
    .brk_req      (brk_req),
    .bp_flat      (bp_flat)
);

// File: tb/dbg_brk_unit_tb_top.sv
module dbg_brk_unit_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bg_cmd = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cfg_reg_mode = 1'b0;
    logic        cfg_dmem_en = 1'b0;
    logic        cpu_in_dbg = 1'b0;
    logic        dmem_vld = 1'b0;
    logic [15:0] dmem_addr = '0;
    logic        dst_vld = 1'b0;
    logic [3:0]  dst_mod = '0;
    logic [4:0]  dst_idx = '0;
    logic        brk_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { bit v; string tag; } item_t;
    item_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    dbg_brk_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bg_cmd(cfg_bg_cmd), .cfg_wr_en(cfg_wr_en),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_reg_mode(cfg_reg_mode), .cfg_dmem_en(cfg_dmem_en), .cpu_in_dbg(cpu_in_dbg),
        .dmem_vld(dmem_vld), .dmem_addr(dmem_addr), .dst_vld(dst_vld),
        .dst_mod(dst_mod), .dst_idx(dst_idx), .brk_req(brk_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected request for each clock edge and compares.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(brk_req == it.v, it.tag, int'(brk_req), int'(it.v));
        end
    end

    // Driver core: queues the expected request for the cycle just set up.
    task automatic cyc(input bit exp, input string tag);
        item_t it;
        it.v = exp;
        it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic quiet();
        cfg_wr_en = 0; dmem_vld = 0; dst_vld = 0;
    endtask

    task automatic wr(input bit bg, input bit sel, input logic [15:0] d, input string tag);
        quiet();
        cfg_bg_cmd = bg; cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = d;
        cyc(0, tag);
        cfg_wr_en = 0; cfg_bg_cmd = 0;
    endtask

    task automatic rd(input bit bg, input bit sel, input logic [15:0] exp, input string tag);
        quiet();
        cfg_bg_cmd = bg; cfg_sel = sel;
        #1;
        check(cfg_rdata == exp, tag, int'(cfg_rdata), int'(exp));
        cyc(0, tag);
        cfg_bg_cmd = 0;
    endtask

    task automatic acc(input logic [15:0] a, input bit vld, input bit exp, input string tag);
        quiet();
        dmem_addr = a; dmem_vld = vld;
        cyc(exp, tag);
        dmem_vld = 0;
    endtask

    task automatic dw(input logic [3:0] m, input logic [4:0] i, input bit vld, input bit exp,
                      input string tag);
        quiet();
        dst_mod = m; dst_idx = i; dst_vld = vld;
        cyc(exp, tag);
        dst_vld = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check(brk_req == 0, "R1 brk_req low after reset", int'(brk_req), 0);
        rd(1, 0, 16'hFFFF, "R1 slot0 reset value");
        rd(1, 1, 16'hFFFF, "R1 slot1 reset value");

        wr(0, 0, 16'h1234, "R3 user write slot0");
        rd(1, 0, 16'hFFFF, "R3 slot0 unchanged by user write");

        wr(1, 0, 16'h1234, "R2 bg write slot0");
        wr(1, 1, 16'hABCD, "R2 bg write slot1");
        rd(1, 0, 16'h1234, "R2 slot0 readback");
        rd(1, 1, 16'hABCD, "R2 slot1 readback");
        rd(0, 0, 16'h0000, "R2 non-bg read returns zero");

        // Address mode
        cfg_reg_mode = 0; cfg_dmem_en = 1;
        acc(16'h1234, 1, 1, "R4 address match slot0");
        acc(16'h1235, 1, 0, "R11 request falls after event");
        acc(16'h0234, 1, 0, "R4 upper address bit differs");
        acc(16'hABCD, 1, 1, "R8 address match slot1 only");
        acc(16'h1234, 1, 1, "R11 back-to-back events");
        acc(16'h1234, 1, 1, "R11 back-to-back events second");
        acc(16'h1234, 0, 0, "R5 no strobe");
        cfg_dmem_en = 0;
        acc(16'h1234, 1, 0, "R5 enable off");
        cfg_dmem_en = 1;
        cpu_in_dbg = 1;
        acc(16'h1234, 1, 0, "R9 suppressed in debug mode (address)");
        cpu_in_dbg = 0;
        acc(16'hABCD, 1, 1, "R4 match after leaving debug mode");

        // Register mode: slot0 = reserved ones, idx 5, mod 10
        wr(1, 0, 16'hFE5A, "R7 write with reserved bits set");
        wr(1, 1, 16'h0113, "R6 write slot1 idx 17 mod 3");
        rd(1, 0, 16'hFE5A, "R7 reserved bits read back");
        cfg_reg_mode = 1;
        dw(4'hA, 5'd5, 1, 1, "R7 reg match ignoring reserved bits");
        dw(4'hA, 5'd5, 0, 0, "R10 no destination write");
        dw(4'hA, 5'd21, 1, 0, "R6 index bit 8 differs");
        dw(4'hB, 5'd5, 1, 0, "R6 module differs");
        dw(4'h3, 5'd17, 1, 1, "R8 reg match slot1 only");
        dw(4'h3, 5'd1, 1, 0, "R6 slot1 index bit 8 required");
        acc(16'hFE5A, 1, 0, "R7 data bus ignored in register mode");
        cpu_in_dbg = 1;
        dw(4'hA, 5'd5, 1, 0, "R9 suppressed in debug mode (register)");
        cpu_in_dbg = 0;
        quiet();
        cyc(0, "R11 idle tail");
        @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule